// File: doc/BRIEF.md
# Frequency-Change Watchdog with Recovery Lock

This block protects a clock generator while its output frequency is being changed. Software arms the watchdog, then requests a frequency change. Each accepted change loads a down counter with a programmed limit. The counter is scaled by one of two time units, and each unit is a fixed number of base ticks. If software does not disarm the watchdog before the counter runs out, the block does three things: it sets a sticky status flag, it enters a locked state that tells the frequency logic to fall back to its recovery setting, and it may pulse a system reset. While the block is locked, further change requests are refused.

A second, independent option pulses the same reset line after every accepted frequency change. The reset output is an open-drain enable: when it is high the line is pulled low, and when it is low the line is released. Each pulse lasts a parameterised number of base ticks.

Top module: `freq_guard_wdt`

## Requirements
- R1: After reset, sts_o, lock_o and rstn_pull_o are all 0, and the counter is idle.
- R2: When wd_en_i is 1, an accepted change starts a countdown. The time-out fires on the clock edge that ends (wd_limit_i+1) time units, counted from the accepting edge. A unit is DIV_SHORT base ticks when wd_long_i is 0 and DIV_LONG base ticks when wd_long_i is 1. sts_o and lock_o become 1 after that same edge.
- R3: With wd_en_i at 1 but no accepted change, the counter never times out.
- R4: An accepted change that arrives while the counter is running reloads the counter and restarts the full time-out window.
- R5: Driving wd_en_i to 0 stops the counter, so a stopped run never times out, and clears lock_o on the next edge.
- R6: While lock_o is 1, a change request is refused: chg_apply_o stays 0, the counter is not loaded, and no change-triggered reset pulse is produced.
- R7: sts_o is sticky. A cycle with sts_wr_i=1 and sts_wdata_i=1 clears it, sts_wdata_i=0 leaves it unchanged, and clearing wd_en_i does not touch it. If a time-out and a clear fall in the same cycle, the time-out wins.
- R8: If rst_on_wd_i is 1 at the time-out edge, rstn_pull_o is 1 from that edge for exactly RST_TICKS base ticks. If rst_on_wd_i is 0, no pulse is produced.
- R9: If rst_on_chg_i is 1, every accepted change drives rstn_pull_o to 1 for RST_TICKS base ticks. If rst_on_chg_i is 0, an accepted change produces no pulse.
- R10: The unit divider and the reset pulse advance only on cycles with tick_i=1. Cycles without a tick delay the time-out and stretch the pulse by the same number of cycles.
- R11: chg_apply_o equals chg_req_i in the same cycle whenever lock_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Base time tick strobe |
| wd_en_i | input | 1 | Watchdog enable; 0 stops the counter and unlocks |
| wd_long_i | input | 1 | Unit select: 0 = DIV_SHORT ticks, 1 = DIV_LONG ticks |
| wd_limit_i | input | TMR_W | Time-out limit; the window is limit+1 units |
| rst_on_wd_i | input | 1 | Pulse reset on time-out |
| rst_on_chg_i | input | 1 | Pulse reset on each accepted change |
| chg_req_i | input | 1 | Frequency change write strobe |
| sts_wr_i | input | 1 | Status write strobe |
| sts_wdata_i | input | 1 | Status write data; 1 clears |
| chg_apply_o | output | 1 | Change request accepted this cycle |
| sts_o | output | 1 | Sticky time-out status |
| lock_o | output | 1 | Recovery lock; forces the recovery frequency |
| rstn_pull_o | output | 1 | Open-drain enable for the active-low reset line |

## Verification
The status flag has two sources that can meet on one edge: the time-out sets it, and a software write of 1 clears it. The bench places the clear strobe on exactly the edge where the arithmetic window (limit+1)*unit ends, and requires the flag to read 1 afterwards. It then puts the clear one edge earlier and requires 0 followed by 1. A second collision is a reload request landing in the middle of a run: the bench expects the time-out to move to a full window after the reload edge, and checks that nothing fires at the original deadline.

// File: rtl/fg_wdt_pkg.sv
package fg_wdt_pkg;

   typedef enum logic {CNT_IDLE = 1'b0, CNT_RUN = 1'b1} cnt_state_e;

   // counter width able to hold values 0..n-1, never below one bit
   function automatic int unsigned cnt_w(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/fg_wdt_unit_div.sv
module fg_wdt_unit_div
   import fg_wdt_pkg::*;
#(
   parameter int unsigned DIV_SHORT = 15,
   parameter int unsigned DIV_LONG  = 250
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic clear_i,
   input  logic long_i,
   output logic unit_o
);
   localparam int unsigned DMAX = (DIV_LONG > DIV_SHORT) ? DIV_LONG : DIV_SHORT;
   localparam int unsigned PW   = cnt_w(DMAX);

   generate
      if (DIV_SHORT < 1 || DIV_LONG < 1) begin : g_bad_div
         $error("fg_wdt_unit_div: both dividers must be at least 1");
      end

      if (DIV_SHORT == 1 && DIV_LONG == 1) begin : g_bypass
         assign unit_o = tick_i & ~clear_i;
         logic unused_ok;
         assign unused_ok = &{1'b0, clk, rst_n, long_i};
      end else begin : g_count
         localparam logic [PW-1:0] LIM_S = PW'(DIV_SHORT - 1);
         localparam logic [PW-1:0] LIM_L = PW'(DIV_LONG - 1);
         logic [PW-1:0] pre_q;
         logic [PW-1:0] lim;
         assign lim    = long_i ? LIM_L : LIM_S;
         assign unit_o = ~clear_i & tick_i & (pre_q == lim);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           pre_q <= '0;
            else if (clear_i)     pre_q <= '0;
            else if (tick_i) begin
               if (pre_q == lim)  pre_q <= '0;
               else               pre_q <= pre_q + PW'(1);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/fg_wdt_count.sv
module fg_wdt_count
   import fg_wdt_pkg::*;
#(
   parameter int unsigned TMR_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic             load_i,
   input  logic [TMR_W-1:0] limit_i,
   input  logic             unit_i,
   output logic             timeout_o,
   output logic             busy_o
);
   localparam int unsigned CW = TMR_W + 1;

   generate
      if (TMR_W < 1) begin : g_bad_w
         $error("fg_wdt_count: TMR_W must be at least 1");
      end
   endgenerate

   cnt_state_e    st_q;
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] start_val;
   logic          last_unit;

   assign start_val = CW'({1'b0, limit_i}) + CW'(1);
   assign last_unit = (st_q == CNT_RUN) & unit_i & (cnt_q == CW'(1));
   assign timeout_o = en_i & ~load_i & last_unit;
   assign busy_o    = (st_q == CNT_RUN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= CNT_IDLE;
         cnt_q <= '0;
      end else if (!en_i) begin
         st_q  <= CNT_IDLE;
         cnt_q <= start_val;
      end else if (load_i) begin
         st_q  <= CNT_RUN;
         cnt_q <= start_val;
      end else if (st_q == CNT_RUN && unit_i) begin
         if (cnt_q == CW'(1)) st_q  <= CNT_IDLE;
         else                 cnt_q <= cnt_q - CW'(1);
      end
   end
endmodule

// File: rtl/fg_wdt_stretch.sv
module fg_wdt_stretch
   import fg_wdt_pkg::*;
#(
   parameter int unsigned RST_TICKS = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic fire_i,
   output logic pull_o
);
   generate
      if (RST_TICKS < 1) begin : g_bad_len
         $error("fg_wdt_stretch: RST_TICKS must be at least 1");
      end

      if (RST_TICKS == 1) begin : g_single
         logic hold_q;
         assign pull_o = hold_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      hold_q <= 1'b0;
            else if (fire_i) hold_q <= 1'b1;
            else if (tick_i) hold_q <= 1'b0;
         end
      end else begin : g_multi
         localparam int unsigned SW = cnt_w(RST_TICKS + 1);
         logic [SW-1:0] left_q;
         assign pull_o = (left_q != '0);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                         left_q <= '0;
            else if (fire_i)                    left_q <= SW'(RST_TICKS);
            else if (tick_i && left_q != '0)    left_q <= left_q - SW'(1);
         end
      end
   endgenerate
endmodule

// File: rtl/freq_guard_wdt.sv
module freq_guard_wdt
   import fg_wdt_pkg::*;
#(
   parameter int unsigned TMR_W     = 5,
   parameter int unsigned DIV_SHORT = 15,
   parameter int unsigned DIV_LONG  = 250,
   parameter int unsigned RST_TICKS = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             wd_en_i,
   input  logic             wd_long_i,
   input  logic [TMR_W-1:0] wd_limit_i,
   input  logic             rst_on_wd_i,
   input  logic             rst_on_chg_i,
   input  logic             chg_req_i,
   input  logic             sts_wr_i,
   input  logic             sts_wdata_i,
   output logic             chg_apply_o,
   output logic             sts_o,
   output logic             lock_o,
   output logic             rstn_pull_o
);
   logic apply, load, timeout, busy, unit, fire;
   logic sts_q, lock_q;

   assign apply = chg_req_i & ~lock_q;
   assign load  = apply & wd_en_i;
   assign fire  = (timeout & rst_on_wd_i) | (apply & rst_on_chg_i);

   fg_wdt_unit_div #(.DIV_SHORT(DIV_SHORT), .DIV_LONG(DIV_LONG)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_i  (tick_i),
      .clear_i (load | ~busy),
      .long_i  (wd_long_i),
      .unit_o  (unit)
   );

   fg_wdt_count #(.TMR_W(TMR_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_i      (wd_en_i),
      .load_i    (load),
      .limit_i   (wd_limit_i),
      .unit_i    (unit),
      .timeout_o (timeout),
      .busy_o    (busy)
   );

   fg_wdt_stretch #(.RST_TICKS(RST_TICKS)) u_rst (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (tick_i),
      .fire_i (fire),
      .pull_o (rstn_pull_o)
   );

   // recovery lock: set by a time-out, released only by disarming
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        lock_q <= 1'b0;
      else if (!wd_en_i) lock_q <= 1'b0;
      else if (timeout)  lock_q <= 1'b1;
   end

   // sticky status: set has priority over a write-one clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          sts_q <= 1'b0;
      else if (timeout)                    sts_q <= 1'b1;
      else if (sts_wr_i && sts_wdata_i)    sts_q <= 1'b0;
   end

   assign chg_apply_o = apply;
   assign sts_o       = sts_q;
   assign lock_o      = lock_q;
endmodule

// File: rtl/fg_wdt_chk.sv
module fg_wdt_chk (
   input logic clk,
   input logic rst_n,
   input logic tick_i,
   input logic wd_en_i,
   input logic rst_on_wd_i,
   input logic rst_on_chg_i,
   input logic sts_wr_i,
   input logic sts_wdata_i,
   input logic chg_apply_o,
   input logic sts_o,
   input logic lock_o,
   input logic rstn_pull_o
);
   // R2: the lock never rises without the status flag
   a_r2_lock_with_status: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_o) |-> sts_o);

   // R6: nothing is accepted while locked
   a_r6_no_apply_locked: assert property (@(posedge clk) disable iff (!rst_n)
      lock_o |-> !chg_apply_o);

   // R5: disarming releases the lock on the next edge
   a_r5_unlock: assert property (@(posedge clk) disable iff (!rst_n)
      !wd_en_i |=> !lock_o);

   // R7: status only falls through a write of one
   a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_o && !(sts_wr_i && sts_wdata_i)) |=> sts_o);

   // R8, R9: a pulse starts only from an enabled source
   a_r9_pull_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rstn_pull_o) |->
         ($past(chg_apply_o && rst_on_chg_i) || ($rose(lock_o) && $past(rst_on_wd_i))));

   // R10: without a tick a running pulse holds
   a_r10_pull_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (rstn_pull_o && !tick_i) |=> rstn_pull_o);
endmodule

bind freq_guard_wdt fg_wdt_chk u_fg_wdt_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .tick_i       (tick_i),
   .wd_en_i      (wd_en_i),
   .rst_on_wd_i  (rst_on_wd_i),
   .rst_on_chg_i (rst_on_chg_i),
   .sts_wr_i     (sts_wr_i),
   .sts_wdata_i  (sts_wdata_i),
   .chg_apply_o  (chg_apply_o),
   .sts_o        (sts_o),
   .lock_o       (lock_o),
   .rstn_pull_o  (rstn_pull_o)
);

// File: tb/tb_freq_guard_wdt.sv
`timescale 1ns/1ps
module tb_freq_guard_wdt;
   localparam int TW = 5;
   localparam int DS = 3;
   localparam int DL = 7;
   localparam int RW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick_i = 1'b1, wd_en_i = 1'b0, wd_long_i = 1'b0;
   logic [TW-1:0] wd_limit_i = '0;
   logic rst_on_wd_i = 1'b0, rst_on_chg_i = 1'b0, chg_req_i = 1'b0;
   logic sts_wr_i = 1'b0, sts_wdata_i = 1'b0;
   logic chg_apply_o, sts_o, lock_o, rstn_pull_o;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   freq_guard_wdt #(.TMR_W(TW), .DIV_SHORT(DS), .DIV_LONG(DL), .RST_TICKS(RW)) dut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wd_en_i(wd_en_i),
      .wd_long_i(wd_long_i), .wd_limit_i(wd_limit_i), .rst_on_wd_i(rst_on_wd_i),
      .rst_on_chg_i(rst_on_chg_i), .chg_req_i(chg_req_i), .sts_wr_i(sts_wr_i),
      .sts_wdata_i(sts_wdata_i), .chg_apply_o(chg_apply_o), .sts_o(sts_o),
      .lock_o(lock_o), .rstn_pull_o(rstn_pull_o));

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   // request a change for one edge; afterwards we sit just past the accepting edge
   task automatic pulse_chg();
      chg_req_i = 1'b1;
      cyc(1);
      chg_req_i = 1'b0;
   endtask

   task automatic unlock_and_clear();
      wd_en_i = 1'b0;
      cyc(1);
      sts_wr_i = 1'b1; sts_wdata_i = 1'b1;
      cyc(1);
      sts_wr_i = 1'b0; sts_wdata_i = 1'b0;
      cyc(RW + 1);
   endtask

   initial begin
      #(5.0 * 150000);
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      cyc(2);
      rst_n = 1'b1;
      cyc(1);
      // R1 reset state
      chk("R1 sts", sts_o, 0);
      chk("R1 lock", lock_o, 0);
      chk("R1 pull", rstn_pull_o, 0);

      // R3 armed but no change: no time-out
      wd_en_i = 1'b1; wd_limit_i = 5'd0;
      cyc(40);
      chk("R3 sts", sts_o, 0);
      chk("R3 lock", lock_o, 0);
      wd_en_i = 1'b0;
      cyc(1);

      // R2 R8 R5 R7 sweep over unit and limit
      for (int lg = 0; lg < 2; lg++) begin
         for (int lim = 0; lim < (1 << TW); lim++) begin
            automatic int n = (lim + 1) * ((lg != 0) ? DL : DS);
            automatic int pw = lim % 2;
            wd_en_i = 1'b1; wd_long_i = lg[0]; wd_limit_i = lim[TW-1:0];
            rst_on_wd_i = pw[0]; rst_on_chg_i = 1'b0;
            pulse_chg();
            cyc(n - 1);
            chk("R2 sts before window end", sts_o, 0);
            cyc(1);
            chk("R2 sts at window end", sts_o, 1);
            chk("R2 lock at window end", lock_o, 1);
            chk("R8 pull at time-out", rstn_pull_o, pw);
            cyc(RW - 1);
            chk("R8 pull last tick", rstn_pull_o, pw);
            cyc(1);
            chk("R8 pull released", rstn_pull_o, 0);
            wd_en_i = 1'b0;
            cyc(1);
            chk("R5 unlock", lock_o, 0);
            chk("R7 status kept on disarm", sts_o, 1);
            sts_wr_i = 1'b1; sts_wdata_i = 1'b1;
            cyc(1);
            sts_wr_i = 1'b0; sts_wdata_i = 1'b0;
            chk("R7 write one clears", sts_o, 0);
         end
      end

      // R9 R11: change-triggered pulse, then time-out without reset
      wd_long_i = 1'b0; wd_limit_i = 5'd2; rst_on_wd_i = 1'b0; rst_on_chg_i = 1'b1;
      wd_en_i = 1'b1;
      chg_req_i = 1'b1;
      #1;
      chk("R11 apply when unlocked", chg_apply_o, 1);
      cyc(1);
      chg_req_i = 1'b0;
      chk("R9 pull after change", rstn_pull_o, 1);
      cyc(RW - 1);
      chk("R9 pull last tick", rstn_pull_o, 1);
      cyc(1);
      chk("R9 pull released", rstn_pull_o, 0);
      cyc(9 - RW - 1);
      chk("R2 sts before end", sts_o, 0);
      cyc(1);
      chk("R2 time-out", sts_o, 1);
      chk("R8 no pull when disabled", rstn_pull_o, 0);
      // R6 locked: request refused, no pulse
      chg_req_i = 1'b1;
      #1;
      chk("R6 apply blocked", chg_apply_o, 0);
      cyc(1);
      chg_req_i = 1'b0;
      chk("R6 no change pulse", rstn_pull_o, 0);
      chk("R6 still locked", lock_o, 1);
      // R7 write of zero has no effect
      sts_wr_i = 1'b1; sts_wdata_i = 1'b0;
      cyc(1);
      sts_wr_i = 1'b0;
      chk("R7 write zero ignored", sts_o, 1);
      unlock_and_clear();
      rst_on_chg_i = 1'b0;

      // R7 time-out and clear on the same edge: set wins
      wd_en_i = 1'b1;
      pulse_chg();
      cyc(8);
      sts_wr_i = 1'b1; sts_wdata_i = 1'b1;
      cyc(1);
      sts_wr_i = 1'b0; sts_wdata_i = 1'b0;
      chk("R7 set beats clear", sts_o, 1);
      unlock_and_clear();

      // R7 clear one edge before time-out
      wd_en_i = 1'b1;
      pulse_chg();
      cyc(7);
      sts_wr_i = 1'b1; sts_wdata_i = 1'b1;
      cyc(1);
      sts_wr_i = 1'b0; sts_wdata_i = 1'b0;
      chk("R7 early clear", sts_o, 0);
      cyc(1);
      chk("R7 then set", sts_o, 1);
      unlock_and_clear();

      // R4 reload mid-run moves the deadline
      wd_en_i = 1'b1;
      pulse_chg();
      cyc(4);
      pulse_chg();
      cyc(8);
      chk("R4 no time-out at old deadline", sts_o, 0);
      cyc(1);
      chk("R4 time-out after reload window", sts_o, 1);
      unlock_and_clear();

      // R5 disarm mid-run stops counting
      wd_en_i = 1'b1;
      pulse_chg();
      cyc(4);
      wd_en_i = 1'b0;
      cyc(3);
      wd_en_i = 1'b1;
      cyc(30);
      chk("R5 stopped run silent", sts_o, 0);
      chk("R5 no lock", lock_o, 0);
      wd_en_i = 1'b0;
      cyc(1);

      // R10 missing ticks delay the time-out and stretch the pulse
      wd_en_i = 1'b1; rst_on_wd_i = 1'b1;
      pulse_chg();
      tick_i = 1'b0;
      cyc(10);
      tick_i = 1'b1;
      cyc(8);
      chk("R10 delayed before end", sts_o, 0);
      tick_i = 1'b0;
      cyc(1);
      chk("R10 no unit without tick", sts_o, 0);
      tick_i = 1'b1;
      cyc(1);
      chk("R10 delayed time-out", sts_o, 1);
      chk("R10 pulse starts", rstn_pull_o, 1);
      tick_i = 1'b0;
      cyc(5);
      tick_i = 1'b1;
      chk("R10 pulse held", rstn_pull_o, 1);
      cyc(RW - 1);
      chk("R10 pulse last tick", rstn_pull_o, 1);
      cyc(1);
      chk("R10 pulse ends", rstn_pull_o, 0);
      unlock_and_clear();

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule